// File: doc/BRIEF.md
# Page write buffer and write-cycle sequencer

This block sits behind the serial protocol engine of a small nonvolatile memory. During a write transaction the engine hands it each received data byte together with the word address that byte targets. The block stores the byte in a page buffer of `PAGE_BYTES` slots, picked by the low address bits, and remembers which slots the transaction has filled. The page (the upper address bits) is taken from the first byte of the transaction and held for the rest of it. If the engine's slot index wraps, a later byte lands on an earlier slot and replaces it.

When the engine reports that a STOP has ended the write, the block starts an internally timed write cycle of exactly `WR_CYCLES` clock cycles, with `busy` high for all of it. In the first `PAGE_BYTES` cycles it scans the slots in ascending order and drives one memory write for each filled slot. During the cycle, bytes and STOPs are ignored. A STOP with no data, or a STOP while the protect input is high, starts nothing and throws away the buffered bytes. Controller states: `ST_IDLE` (no transaction data), `ST_FILL` (collecting bytes), `ST_SCAN` (busy, committing slots), `ST_SETTLE` (busy, waiting out the rest of the cycle). The transitions are:
- `ST_IDLE`→`ST_FILL` on an accepted byte.
- `ST_FILL`→`ST_SCAN` on a STOP with protect low.
- `ST_FILL`→`ST_IDLE` on a STOP with protect high.
- `ST_SCAN`→`ST_SETTLE` after the last slot, or `ST_SCAN`→`ST_IDLE` if the cycle ends there.
- `ST_SETTLE`→`ST_IDLE` at the end of the cycle.

Top module: `pgwr_seq`

## Requirements
- R1: After reset `busy` and `mem_we` are 0.
- R2: A byte strobed with address A goes to slot A[4:0]. The commit writes it to memory address {P, A[4:0]}, where P is bits [12:5] of the first byte's address in the same transaction.
- R3: When two bytes of one transaction hit the same slot, only the later data is committed, and that slot is written once.
- R4: Only the slots filled in the transaction are written. The writes come in ascending slot order, and the write for slot k is in the (k+1)-th busy cycle.
- R5: A STOP accepted with data buffered and `wp` low raises `busy` from the next cycle for exactly `WR_CYCLES` cycles.
- R6: While `busy` is high, byte strobes and STOPs are ignored: they cause no write, no change to the cycle length, and nothing in a later commit.
- R7: A STOP with no byte accepted since the last STOP starts no cycle: `busy` stays 0 and no write occurs.
- R8: A STOP with `wp` high starts no cycle, writes nothing, and discards the buffered bytes.
- R9: A byte strobed in the same cycle as a STOP is discarded.
- R10: The filled-slot mask clears after each cycle, so the next transaction commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_stb | input | 1 | One-cycle strobe: a data byte is offered |
| byte_addr | input | 13 | Word address of the offered byte |
| byte_data | input | 8 | Offered data byte |
| stop_wr | input | 1 | One-cycle pulse: STOP ended a write transaction |
| wp | input | 1 | Whole-array write protect, high inhibits programming |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory write address |
| mem_data | output | 8 | Memory write data |

## Verification
The bench sends a transaction longer than a page that starts near the top slot. A design that did not wrap, or that committed both copies of a slot, would make an extra or wrong write. Sparse bytes whose later addresses carry a different upper part show whether the page stays fixed from the first byte; a design that followed each address would write outside the page. Empty STOPs, protected STOPs, a STOP with a byte in the same cycle, and a byte and STOP injected mid-cycle check that nothing leaks into memory or into a later commit and that the busy length never changes. A design that kept the slot mask across cycles would repeat old writes after a small transaction.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_SCAN,
        ST_SETTLE
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_slots.sv
// Page buffer: one data register and one filled flag per slot.
module pgwr_slots #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] slot_data [SLOTS];
    logic [SLOTS-1:0]  slot_full;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              f;
        logic              hit;

        assign hit = wr_en && (wr_slot == SLOT_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit) begin
                q <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                f <= 1'b0;
            end else if (clr) begin
                f <= 1'b0;
            end else if (hit) begin
                f <= 1'b1;
            end
        end

        assign slot_data[g] = q;
        assign slot_full[g] = f;
    end

    assign rd_data  = slot_data[rd_slot];
    assign rd_valid = slot_full[rd_slot];
endmodule

// File: rtl/pgwr_timer.sv
// Write-cycle timer: counts busy cycles, flags the end of scan and of cycle.
module pgwr_timer #(
    parameter int WR_CYCLES = 500000,
    parameter int SLOTS     = 32,
    localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             scan_last,
    output logic             cycle_last
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(SLOTS - 1);

    assign scan_last  = (cnt == SCAN_END);
    assign cycle_last = (cnt == LAST_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !cycle_last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/pgwr_fsm.sv
// Transaction and write-cycle controller.
module pgwr_fsm
    import pgwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_stb,
    input  logic        stop_wr,
    input  logic        wp,
    input  logic        scan_last,
    input  logic        cycle_last,
    input  logic        slot_valid,
    output pgwr_state_e state,
    output logic        accept,
    output logic        take_page,
    output logic        clr_mask,
    output logic        run,
    output logic        commit_we
);
    pgwr_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (byte_stb && !stop_wr) state_nx = ST_FILL;
            end
            ST_FILL: begin
                if (stop_wr) state_nx = wp ? ST_IDLE : ST_SCAN;
            end
            ST_SCAN: begin
                if (cycle_last)     state_nx = ST_IDLE;
                else if (scan_last) state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cycle_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        take_page = 1'b0;
        clr_mask  = 1'b0;
        run       = 1'b0;
        commit_we = 1'b0;
        unique case (state)
            ST_IDLE: begin
                accept    = byte_stb && !stop_wr;
                take_page = byte_stb && !stop_wr;
            end
            ST_FILL: begin
                accept   = byte_stb && !stop_wr;
                clr_mask = stop_wr && wp;
            end
            ST_SCAN: begin
                run       = 1'b1;
                commit_we = slot_valid;
                clr_mask  = cycle_last;
            end
            ST_SETTLE: begin
                run      = 1'b1;
                clr_mask = cycle_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pgwr_seq.sv
// Top: page buffer plus timed commit to the memory write port.
module pgwr_seq #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_wr,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    import pgwr_pkg::*;

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    pgwr_state_e       state;
    logic              accept, take_page, clr_mask, run, commit_we;
    logic              scan_last, cycle_last, slot_valid;
    logic [CNT_W-1:0]  cnt;
    logic [PAGE_W-1:0] page_q;
    logic [SLOT_W-1:0] scan_slot;

    assign scan_slot = cnt[SLOT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (take_page) begin
            page_q <= byte_addr[ADDR_W-1:SLOT_W];
        end
    end

    pgwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_stb   (byte_stb),
        .stop_wr    (stop_wr),
        .wp         (wp),
        .scan_last  (scan_last),
        .cycle_last (cycle_last),
        .slot_valid (slot_valid),
        .state      (state),
        .accept     (accept),
        .take_page  (take_page),
        .clr_mask   (clr_mask),
        .run        (run),
        .commit_we  (commit_we)
    );

    pgwr_timer #(
        .WR_CYCLES (WR_CYCLES),
        .SLOTS     (PAGE_BYTES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cnt        (cnt),
        .scan_last  (scan_last),
        .cycle_last (cycle_last)
    );

    pgwr_slots #(
        .DATA_W (DATA_W),
        .SLOTS  (PAGE_BYTES)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_slot  (byte_addr[SLOT_W-1:0]),
        .wr_data  (byte_data),
        .clr      (clr_mask),
        .rd_slot  (scan_slot),
        .rd_data  (mem_data),
        .rd_valid (slot_valid)
    );

    assign busy     = run;
    assign mem_we   = commit_we;
    assign mem_addr = {page_q, scan_slot};
endmodule

// File: rtl/pgwr_seq_chk.sv
// Port-level checker bound to the top module.
module pgwr_seq_chk #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_stb,
    input logic              stop_wr,
    input logic              wp,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);

    logic        seen;
    int unsigned len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            len_q <= 0;
        end else begin
            len_q <= busy ? len_q + 1 : 0;
            if (!busy) begin
                if (stop_wr)       seen <= 1'b0;
                else if (byte_stb) seen <= 1'b1;
            end
        end
    end

    // R4: memory writes only inside the scan part of a busy cycle
    p_we_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && (len_q < PAGE_BYTES)));

    // R5: STOP with data and no protect starts a cycle
    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !busy && !wp && seen) |=> busy);

    // R5: cycle length is exact
    p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_q == WR_CYCLES));

    // R6: busy only ever starts from a STOP
    p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_wr));

    // R7: STOP without data starts nothing
    p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !busy && !seen) |=> !busy);

    // R8: protected STOP starts nothing
    p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !busy && wp) |=> !busy);

    // R2: page stays fixed through the cycle
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:SLOT_W]));
endmodule

bind pgwr_seq pgwr_seq_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (byte_stb),
    .stop_wr  (stop_wr),
    .wp       (wp),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/tb_pgwr_seq.sv
`timescale 1ns/1ps
module tb_pgwr_seq;
    localparam int WR_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_stb = 1'b0;
    logic [12:0] byte_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        stop_wr = 1'b0;
    logic        wp = 1'b0;
    logic        busy, mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;

    int checks = 0;
    int fails  = 0;

    logic [20:0] exp_q [$];

    logic [7:0] m_data [32];
    bit         m_full [32];
    logic [7:0] m_page;
    bit         m_any;

    always #5 clk = ~clk;

    pgwr_seq #(.WR_CYCLES(WR_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_addr(byte_addr),
        .byte_data(byte_data), .stop_wr(stop_wr), .wp(wp), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor: pops the scoreboard on every memory write (R2 R3 R4)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected write", {mem_addr, mem_data}, 0);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_data} == e, "R2/R3/R4 write", {mem_addr, mem_data}, e);
            end
        end
    end

    task automatic model_clear();
        for (int i = 0; i < 32; i++) m_full[i] = 0;
        m_any = 0;
    endtask

    task automatic put_byte(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        byte_stb = 1'b1; byte_addr = a; byte_data = d;
        if (!m_any) m_page = a[12:5];
        m_any = 1;
        m_data[a[4:0]] = d;
        m_full[a[4:0]] = 1;
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    // ends a transaction; optional byte in the same cycle (R9); optional injection while busy (R6)
    task automatic do_stop(input bit prot, input bit with_byte, input bit inject, input string req);
        bit expect_busy;
        int n;
        @(negedge clk);
        wp = prot;
        stop_wr = 1'b1;
        if (with_byte) begin
            byte_stb = 1'b1; byte_addr = 13'h1FFF; byte_data = 8'hEE;
        end
        expect_busy = m_any && !prot;
        if (expect_busy)
            for (int i = 0; i < 32; i++)
                if (m_full[i]) exp_q.push_back({m_page, i[4:0], m_data[i]});
        model_clear();
        @(negedge clk);
        stop_wr = 1'b0; byte_stb = 1'b0; wp = 1'b0;
        check(busy == expect_busy, {req, " busy after stop"}, busy, expect_busy);
        if (expect_busy) begin
            n = 0;
            while (busy) begin
                n++;
                if (inject && n == 5) begin
                    byte_stb = 1'b1; byte_addr = 13'h0ABC; byte_data = 8'h77;
                end else if (inject && n == 6) begin
                    byte_stb = 1'b0; stop_wr = 1'b1;
                end else if (inject && n == 7) begin
                    stop_wr = 1'b0;
                end
                @(negedge clk);
            end
            check(n == WR_CYC, "R5 busy length", n, WR_CYC);
        end else begin
            n = 0;
            for (int i = 0; i < 6; i++) begin
                if (busy) n++;
                @(negedge clk);
            end
            check(n == 0, {req, " busy stays low"}, n, 0);
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {req, " all writes seen"}, exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 10);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        model_clear();
        m_page = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        check(mem_we == 1'b0, "R1 mem_we at reset", mem_we, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R5: single byte
        put_byte(13'h0123, 8'hA5);
        do_stop(0, 0, 0, "R2");

        // R4: full page from slot 7, wrapping
        for (int i = 0; i < 32; i++)
            put_byte({8'h55, 5'((7 + i) % 32)}, 8'(8'h10 + i));
        do_stop(0, 0, 0, "R4");

        // R10: next small transaction commits only its own slot
        put_byte({8'h55, 5'd2}, 8'h3C);
        do_stop(0, 0, 0, "R10");

        // R3: 40 bytes from slot 30, wrap overwrite
        for (int i = 0; i < 40; i++)
            put_byte({8'h9A, 5'((30 + i) % 32)}, 8'(8'hC0 ^ i));
        do_stop(0, 0, 0, "R3");

        // R2: sparse slots; later addresses carry other upper bits
        put_byte({8'h21, 5'd17}, 8'h01);
        put_byte({8'h7F, 5'd3},  8'h02);
        put_byte({8'h00, 5'd9},  8'h03);
        do_stop(0, 0, 0, "R2");

        // R7: STOP with no data
        do_stop(0, 0, 0, "R7");

        // R8: protected STOP discards the buffer
        put_byte({8'h44, 5'd5}, 8'h5A);
        put_byte({8'h44, 5'd6}, 8'h5B);
        do_stop(1, 0, 0, "R8");
        put_byte({8'h12, 5'd4}, 8'h99);
        do_stop(0, 0, 0, "R8");

        // R6: byte and STOP during busy are ignored
        put_byte({8'h33, 5'd0}, 8'h42);
        do_stop(0, 0, 1, "R6");
        do_stop(0, 0, 0, "R6");
        put_byte({8'h33, 5'd8}, 8'h43);
        do_stop(0, 0, 0, "R6");

        // R9: byte together with STOP is dropped
        put_byte({8'h61, 5'd1}, 8'hD1);
        do_stop(0, 1, 0, "R9");
        do_stop(0, 0, 0, "R9");

        finish_run();
    end
endmodule